// File: doc/BRIEF.md
# System Control Register Bank

This block is a memory-mapped control register bank that sits in a 4 KB window on a simple word-wide bus. The bus has a byte address, a read strobe, a write strobe, write data and registered read data. The lower half of the window holds 512 words of 32-bit storage. A few identification words come out of reset with fixed nonzero contents, and three status words always read with two ready bits set.

A dedicated command offset in the upper half of the window has no storage behind it. Instead, a write there turns into a single-cycle system reset request or shutdown request, depending on the value written. Any access that lands above the storage region reads as zero, stores nothing and raises a one-cycle bad-access flag. Downstream sequencing logic consumes the request pulses and the flag.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset, word index 0x40 (byte 0x100) reads 0x05F20121 plus forced bits, 0x41 (byte 0x104) reads 0x00000002, 0x42 (byte 0x108) reads 0x05F30121, 0x43 (byte 0x10C) reads 0x05F40121, and every other backed word reads 0.
- R2: A write to a backed word (byte offset 0x000 to 0x7FC) stores all 32 bits. A later read of that word returns the new value.
- R3: Read data is registered. It shows the addressed word in the cycle after a read strobe and holds its value in cycles without a read strobe.
- R4: Reads of byte offsets 0x100, 0x108 and 0x10C return the stored word ORed with 0x30000000. Reads of all other offsets, including 0x104, return the stored word unaltered.
- R5: A write of 1 or 2 to byte offset 0xF00 drives reset_req high for exactly the one cycle after the write.
- R6: A write of 3 to byte offset 0xF00 drives shutdown_req high for the one cycle after the write. Any other value written there raises neither request, and reset_req and shutdown_req are never high together.
- R7: A read at byte offset 0x800 or above returns 0 and drives bad_access high for the one cycle after the access.
- R8: A write at byte offset 0x800 or above, including 0xF00, stores nothing and drives bad_access high for the one cycle after the access.
- R9: Address bits [1:0] are ignored. The word index is address bits [11:2].
- R10: During and right after reset, read data, bad_access, reset_req and shutdown_req are 0. bad_access stays 0 in cycles that follow no access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte address within the window |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bad_access | output | 1 | One-cycle pulse for an access above the storage region |
| reset_req | output | 1 | One-cycle system reset request |
| shutdown_req | output | 1 | One-cycle shutdown request |

## Verification
The bench focuses on the command offset. A write of 0 or 4 there must raise no request, while a write of 1, 2 or 3 must raise exactly one request. A design that stored the command write would show it again when the aliased word 0x700 is read back. The forced-bit words are written with zero and read back: a design that ORed the bits into storage, or forced them at 0x104, would return the wrong value. Out-of-range writes are followed by reads of the low-half word they would alias if the top address bit were dropped, which exposes a decoder that wraps instead of discarding. Low address bits are set on every access to catch a design that indexes by byte.

// File: rtl/sysctl_pkg.sv
// Shared constants and reset contents for the system control register bank.
package sysctl_pkg;
    localparam int unsigned ADDR_W      = 12;
    localparam int unsigned DATA_W      = 32;
    localparam int unsigned STORE_WORDS = 512;
    localparam int unsigned WIDX_W      = ADDR_W - 2;
    localparam int unsigned CMD_WIDX    = 'h3C0;          // byte 0xF00
    localparam logic [DATA_W-1:0] READY_BITS = 32'h3000_0000;
    localparam int unsigned NUM_FORCED  = 3;

    // Word indices whose reads carry the ready bits.
    function automatic logic is_forced(input int unsigned idx);
        return (idx == 'h40) || (idx == 'h42) || (idx == 'h43);
    endfunction

    // Reset contents of a backed word.
    function automatic logic [DATA_W-1:0] reset_word(input int unsigned idx);
        case (idx)
            'h40:    return 32'h05F2_0121;
            'h41:    return 32'h0000_0002;
            'h42:    return 32'h05F3_0121;
            'h43:    return 32'h05F4_0121;
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/sysctl_decode.sv
// Address decoder: splits a byte address into a word index and classifies it.
// Assumes the window is ADDR_W bits wide and storage occupies its low words.
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int unsigned A_W   = ADDR_W,
    parameter int unsigned WORDS = STORE_WORDS
) (
    input  logic [A_W-1:0] addr,
    output logic [A_W-3:0] widx,
    output logic           in_store,
    output logic           cmd_hit,
    output logic           force_hit
);
    // Word index drops the byte-lane bits.
    always_comb widx = addr[A_W-1:2];

    // Classify the word index.
    always_comb begin
        in_store  = (int'(widx) < WORDS);
        cmd_hit   = (int'(widx) == CMD_WIDX);
        force_hit = in_store && is_forced(int'(widx));
    end
endmodule

// File: rtl/sysctl_store.sv
// Backed word storage with registered read port and forced ready bits.
// Assumes callers only write when the index is in range.
module sysctl_store
    import sysctl_pkg::*;
#(
    parameter int unsigned WORDS = STORE_WORDS,
    parameter int unsigned D_W   = DATA_W,
    parameter int unsigned I_W   = WIDX_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [I_W-1:0] widx,
    input  logic           wr_en,
    input  logic           rd_en,
    input  logic           in_store,
    input  logic           force_hit,
    input  logic [D_W-1:0] wdata,
    output logic [D_W-1:0] rdata
);
    localparam int unsigned SEL_W = $clog2(WORDS);

    logic [D_W-1:0]   mem [WORDS];
    logic [SEL_W-1:0] sel;

    always_comb sel = widx[SEL_W-1:0];

    // Load reset contents, then accept in-range writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= reset_word(i);
        end else if (wr_en && in_store) begin
            mem[sel] <= wdata;
        end
    end

    // Register read data; out-of-range reads return zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= in_store ? (mem[sel] | (force_hit ? READY_BITS : '0)) : '0;
    end

    // R3: without a read strobe the read data holds.
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
    // R7: an out-of-range read yields zero.
    a_r7_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !in_store) |=> (rdata == '0));
endmodule

// File: rtl/sysctl_cmd.sv
// Command decoder: turns a write at the command offset into request pulses.
// Reset codes take priority; the codes do not overlap, so both never fire.
module sysctl_cmd
    import sysctl_pkg::*;
#(
    parameter int unsigned D_W = DATA_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           cmd_hit,
    input  logic [D_W-1:0] wdata,
    output logic           reset_req,
    output logic           shutdown_req
);
    logic want_reset, want_down;

    // Decode the command value.
    always_comb begin
        want_reset = wr_en && cmd_hit && ((wdata == D_W'(1)) || (wdata == D_W'(2)));
        want_down  = wr_en && cmd_hit && (wdata == D_W'(3)) && !want_reset;
    end

    // Register the single-cycle request pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_req    <= 1'b0;
            shutdown_req <= 1'b0;
        end else begin
            reset_req    <= want_reset;
            shutdown_req <= want_down;
        end
    end

    // R6: the two requests are mutually exclusive.
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(reset_req && shutdown_req));
    // R5: a request pulse only follows a command write.
    a_r5_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req || shutdown_req) |-> $past(wr_en && cmd_hit));
endmodule

// File: rtl/sysctl_regbank.sv
// System control register bank top: decode, storage, command pulses and
// the bad-access flag. Assumes a word-wide bus with one access per strobe.
module sysctl_regbank
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bad_access,
    output logic              reset_req,
    output logic              shutdown_req
);
    logic [WIDX_W-1:0] widx;
    logic              in_store, cmd_hit, force_hit;

    sysctl_decode #(.A_W(ADDR_W), .WORDS(STORE_WORDS)) u_dec (
        .addr(bus_addr), .widx(widx), .in_store(in_store),
        .cmd_hit(cmd_hit), .force_hit(force_hit)
    );

    sysctl_store #(.WORDS(STORE_WORDS), .D_W(DATA_W), .I_W(WIDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .widx(widx), .wr_en(bus_wr), .rd_en(bus_rd),
        .in_store(in_store), .force_hit(force_hit), .wdata(bus_wdata),
        .rdata(bus_rdata)
    );

    sysctl_cmd #(.D_W(DATA_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .cmd_hit(cmd_hit),
        .wdata(bus_wdata), .reset_req(reset_req), .shutdown_req(shutdown_req)
    );

    // Flag any access above the storage region for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) bad_access <= 1'b0;
        else        bad_access <= (bus_rd || bus_wr) && !in_store;
    end

    // R10: the flag is only raised after an access.
    a_r10_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
        bad_access |-> $past(bus_rd || bus_wr));
    // R8: a command write always flags a bad access.
    a_r8_cmd_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req || shutdown_req) |-> bad_access);
endmodule

// File: tb/sim_sysctl_regbank.sv
module sim_sysctl_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bad_access, reset_req, shutdown_req;

    int errors = 0;
    int checks = 0;

    // Reference model state.
    logic [31:0] ref_mem [512];
    logic [31:0] exp_rdata = '0;

    always #5 clk = ~clk;

    sysctl_regbank u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bad_access(bad_access), .reset_req(reset_req), .shutdown_req(shutdown_req)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_reset(input int i);
        case (i)
            'h40: return 32'h05F20121;
            'h41: return 32'h00000002;
            'h42: return 32'h05F30121;
            'h43: return 32'h05F40121;
            default: return 32'h0;
        endcase
    endfunction

    // One bus cycle, then compare every output against the model.
    task automatic op(input bit rd, input bit wr, input logic [11:0] a,
                      input logic [31:0] d, input string tag);
        int  w;
        bit  inr;
        bit  e_bad, e_rst, e_down;
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        w   = int'(a[11:2]);
        inr = (w < 512);
        if (rd) begin
            if (inr) begin
                exp_rdata = ref_mem[w];
                if (w == 'h40 || w == 'h42 || w == 'h43) exp_rdata |= 32'h30000000;
            end else exp_rdata = 32'h0;
        end
        e_bad  = (rd || wr) && !inr;
        e_rst  = wr && (w == 'h3C0) && (d == 1 || d == 2);
        e_down = wr && (w == 'h3C0) && (d == 3);
        if (wr && inr) ref_mem[w] = d;
        check(tag, "rdata", bus_rdata, exp_rdata);
        check(tag, "bad_access", 32'(bad_access), 32'(e_bad));
        check(tag, "reset_req", 32'(reset_req), 32'(e_rst));
        check(tag, "shutdown_req", 32'(shutdown_req), 32'(e_down));
        bus_rd = 1'b0; bus_wr = 1'b0;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] lcg;
        for (int i = 0; i < 512; i++) ref_mem[i] = ref_reset(i);
        // R10: reset state, with a read strobe held during reset.
        bus_rd = 1'b1; bus_addr = 12'h100;
        repeat (3) @(negedge clk);
        bus_rd = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", "rdata", bus_rdata, 32'h0);
        check("R10", "bad_access", 32'(bad_access), 32'h0);
        check("R10", "reset_req", 32'(reset_req), 32'h0);
        check("R10", "shutdown_req", 32'(shutdown_req), 32'h0);

        // R1 / R4: identification words after reset.
        op(1, 0, 12'h100, 0, "R1");
        op(1, 0, 12'h104, 0, "R1");
        op(1, 0, 12'h108, 0, "R1");
        op(1, 0, 12'h10C, 0, "R1");
        op(1, 0, 12'h000, 0, "R1");
        op(1, 0, 12'h7FC, 0, "R1");
        op(1, 0, 12'h110, 0, "R1");
        // R2: write then read.
        op(0, 1, 12'h104, 32'hDEADBEEF, "R2");
        op(1, 0, 12'h104, 0, "R2");
        op(0, 1, 12'h7FC, 32'hA5A5_5A5A, "R2");
        op(1, 0, 12'h7FC, 0, "R2");
        // R4: forced bits over written zero and all-ones.
        op(0, 1, 12'h100, 32'h0, "R4");
        op(1, 0, 12'h100, 0, "R4");
        op(0, 1, 12'h108, 32'hFFFF_FFFF, "R4");
        op(1, 0, 12'h108, 0, "R4");
        op(0, 1, 12'h10C, 32'h0000_0001, "R4");
        op(1, 0, 12'h10C, 0, "R4");
        // R3: read data holds across idle and write cycles.
        op(0, 0, 12'h000, 0, "R3");
        op(0, 1, 12'h10C, 32'h1234_5678, "R3");
        op(0, 0, 12'h000, 0, "R3");
        op(1, 0, 12'h10C, 0, "R3");
        // R9: low address bits ignored.
        op(0, 1, 12'h207, 32'hCAFE_0001, "R9");
        op(1, 0, 12'h204, 0, "R9");
        op(1, 0, 12'h102, 0, "R9");
        // R5 / R6: command codes, with the aliased word read afterwards.
        op(0, 1, 12'hF00, 32'd1, "R5");
        op(0, 1, 12'hF00, 32'd2, "R5");
        op(0, 1, 12'hF03, 32'd2, "R5");
        op(0, 1, 12'hF00, 32'd3, "R6");
        op(0, 1, 12'hF00, 32'd0, "R6");
        op(0, 1, 12'hF00, 32'd4, "R6");
        op(0, 1, 12'hF00, 32'h8000_0001, "R6");
        op(1, 0, 12'hF00, 0, "R7");
        op(1, 0, 12'h700, 0, "R8");
        // R7 / R8: out-of-range reads and discarded writes.
        op(1, 0, 12'h800, 0, "R7");
        op(1, 0, 12'hFFC, 0, "R7");
        op(0, 1, 12'h800, 32'h1111_2222, "R8");
        op(1, 0, 12'h000, 0, "R8");
        op(0, 1, 12'h904, 32'h3333_4444, "R8");
        op(1, 0, 12'h104, 0, "R8");
        op(0, 0, 12'h800, 0, "R10");
        // Mixed pattern across the whole window.
        lcg = 32'h1357_9BDF;
        for (int n = 0; n < 400; n++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            if (lcg[31:30] == 2'b00)
                op(0, 1, 12'hF00, {30'h0, lcg[5:4]}, "R5");
            else if (lcg[29])
                op(0, 1, {lcg[20], 2'b00, lcg[17:13], lcg[3:0]}, lcg ^ 32'h5A5A_0000, "R2");
            else
                op(1, 0, {lcg[20], 2'b00, lcg[17:13], lcg[3:0]}, 0, "R3");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule